// File: doc/BRIEF.md
# Priority Preemption Arbiter

This block sits between a set of interrupt sources and a processor. Every source has its own request line and its own 4-bit priority level. The first eight sources are software-raised, and the rest are peripheral lines. Each clock, the block finds the asserted source with the highest level. It then compares that level against the level of the service routine now running, which is the current-priority input. The block raises its processor request only when the winner is strictly above the current level. Together with the request it presents the winner's fixed 9-bit vector and its level, so that an acknowledge register can latch them.

The vector of a source is its index. Software sources take vectors 0 to 7, and peripheral source k takes vector 8+k. When several asserted sources share the top level, the lowest vector wins.

All inputs pass through the same three register stages, so the request, vector and level outputs always reflect one consistent sample of the inputs. That sample was taken three rising edges earlier. All pins are plain level signals with no handshake. The outputs are valid every cycle, and the processor side needs no back-pressure.

Top module: `irq_preempt_arbiter`

## Requirements
- R1: While reset is low, and on leaving reset, `cpu_irq`, `ack_vec` and `win_prio` are all 0.
- R2: Among the asserted requests, the source with the highest priority field is chosen. Its vector is its index: bit i of `src_req` has vector i, with 0..7 for software sources and 8 upward for peripheral sources.
- R3: `cpu_irq` is 1 only if the chosen priority is strictly greater than `cur_prio`. A priority equal to `cur_prio` does not assert it.
- R4: When two or more asserted sources share the highest priority, the one with the lowest vector is chosen.
- R5: A source whose priority field is 0 never causes `cpu_irq` to assert.
- R6: A change on `src_req`, `src_prio` or `cur_prio` that is set up before rising edge e is seen on the outputs just after edge e+2, which is three clocks. The outputs keep their old values after edges e and e+1.
- R7: Whenever `cpu_irq` is 0, `ack_vec` and `win_prio` are 0.
- R8: A source whose request bit is 0 has no effect on the outputs, whatever its priority field holds. Source i's priority is `src_prio[4*i+3:4*i]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | NUM_SW+NUM_PERIPH | Request line per source, bit i is vector i |
| src_prio | input | 4*(NUM_SW+NUM_PERIPH) | Priority field per source, 4 bits each, source i in bits 4i+3..4i |
| cur_prio | input | 4 | Priority of the routine now executing |
| cpu_irq | output | 1 | Interrupt request to the processor |
| ack_vec | output | 9 | Vector of the preempting source, 0 when idle |
| win_prio | output | 4 | Priority of the preempting source, 0 when idle |

## Verification
The tie-break among equal top priorities and the strict gate against the current level act in the same cycle on the same candidate. Vectors 7 and 23 both carry level 7, so the bench raises both together. It then moves `cur_prio` to 6 and to 7. It expects vector 7 to win while the gate is open, and expects all outputs to be silent when the tied level equals the current level. Zero-level requests mixed with higher ones check that the gate, not the tie-break, blocks them.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  parameter int PRIO_W = 4;
  parameter int VEC_W  = 9;
  parameter int NUM_SW = 8;

  typedef struct packed {
    logic              valid;
    logic [PRIO_W-1:0] prio;
    logic [VEC_W-1:0]  idx;
  } cand_t;

  // lo always holds the lower vector; it keeps a tie
  function automatic cand_t pick_cand(input cand_t lo, input cand_t hi);
    if (hi.valid && (!lo.valid || hi.prio > lo.prio)) return hi;
    return lo;
  endfunction
endpackage

// File: rtl/irq_capture_stage.sv
module irq_capture_stage
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 24
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        req_in,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_in,
  input  logic [PRIO_W-1:0]         cur_in,
  output logic [NUM_SRC-1:0]        req_q,
  output logic [PRIO_W-1:0]         prio_q [NUM_SRC],
  output logic [PRIO_W-1:0]         cur_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      cur_q <= '0;
    end else begin
      req_q <= req_in;
      cur_q <= cur_in;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prio_q[i] <= '0;
      else        prio_q[i] <= prio_in[i*PRIO_W +: PRIO_W];
    end
  end
endmodule

// File: rtl/irq_winner_tree.sv
module irq_winner_tree
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_q,
  input  logic [PRIO_W-1:0]  prio_q [NUM_SRC],
  input  logic [PRIO_W-1:0]  cur_q,
  output cand_t              win_q,
  output logic [PRIO_W-1:0]  cur_qq
);
  localparam int LEVELS = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int LEAVES = 1 << LEVELS;

  cand_t leaf [LEAVES];
  cand_t win_d;

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < NUM_SRC) begin : g_real
      assign leaf[i] = '{valid: req_q[i], prio: prio_q[i], idx: VEC_W'(i)};
    end else begin : g_pad
      assign leaf[i] = '0;
    end
  end

  always_comb begin
    cand_t work [LEAVES];
    for (int k = 0; k < LEAVES; k++) work[k] = leaf[k];
    for (int l = 0; l < LEVELS; l++) begin
      for (int k = 0; k < LEAVES; k += (2 << l)) begin
        work[k] = pick_cand(work[k], work[k + (1 << l)]);
      end
    end
    win_d = work[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      cur_qq <= '0;
    end else begin
      win_q  <= win_d;
      cur_qq <= cur_q;
    end
  end

  // R8: a chosen winner always had its request bit set in the prior stage
  p_winner_requested_r8: assert property (@(posedge clk) disable iff (!rst_n)
    win_q.valid |-> ((($past(req_q)) >> win_q.idx) & NUM_SRC'(1)) != '0);
endmodule

// File: rtl/irq_preempt_gate.sv
module irq_preempt_gate
  import irq_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cand_t             win_q,
  input  logic [PRIO_W-1:0] cur_qq,
  output logic              irq_q,
  output logic [VEC_W-1:0]  vec_q,
  output logic [PRIO_W-1:0] prio_q
);
  logic preempt;
  assign preempt = win_q.valid && (win_q.prio > cur_qq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      vec_q  <= '0;
      prio_q <= '0;
    end else begin
      irq_q  <= preempt;
      vec_q  <= preempt ? win_q.idx  : '0;
      prio_q <= preempt ? win_q.prio : '0;
    end
  end

  p_zero_never_fires_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> prio_q != '0);
  p_idle_outputs_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_q |-> (vec_q == '0 && prio_q == '0));
endmodule

// File: rtl/irq_preempt_arbiter.sv
module irq_preempt_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_PERIPH = 16,
  localparam int NUM_SRC   = NUM_SW + NUM_PERIPH
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        src_req,
  input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
  input  logic [PRIO_W-1:0]         cur_prio,
  output logic                      cpu_irq,
  output logic [VEC_W-1:0]          ack_vec,
  output logic [PRIO_W-1:0]         win_prio
);
  logic [NUM_SRC-1:0] s1_req;
  logic [PRIO_W-1:0]  s1_prio [NUM_SRC];
  logic [PRIO_W-1:0]  s1_cur;
  cand_t              s2_win;
  logic [PRIO_W-1:0]  s2_cur;

  irq_capture_stage #(.NUM_SRC(NUM_SRC)) u_capture (
    .clk(clk), .rst_n(rst_n), .req_in(src_req), .prio_in(src_prio),
    .cur_in(cur_prio), .req_q(s1_req), .prio_q(s1_prio), .cur_q(s1_cur)
  );

  irq_winner_tree #(.NUM_SRC(NUM_SRC)) u_tree (
    .clk(clk), .rst_n(rst_n), .req_q(s1_req), .prio_q(s1_prio),
    .cur_q(s1_cur), .win_q(s2_win), .cur_qq(s2_cur)
  );

  irq_preempt_gate u_gate (
    .clk(clk), .rst_n(rst_n), .win_q(s2_win), .cur_qq(s2_cur),
    .irq_q(cpu_irq), .vec_q(ack_vec), .prio_q(win_prio)
  );

  // R3 and R6: level is strictly above the current level sampled three edges back
  p_above_current_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> win_prio > $past(cur_prio, 3));
  // R2: the vector names a real source that was requesting three edges back
  p_vector_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> ack_vec < VEC_W'(NUM_SRC));
  p_vector_requested_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> ((($past(src_req, 3)) >> ack_vec) & NUM_SRC'(1)) != '0);
endmodule

// File: tb/tb_irq_preempt_arbiter.sv
module tb_irq_preempt_arbiter;
  localparam int N = 24;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   src_req = '0;
  logic [N*4-1:0] src_prio = '0;
  logic [3:0]     cur_prio = '0;
  logic           cpu_irq;
  logic [8:0]     ack_vec;
  logic [3:0]     win_prio;

  int checks = 0;
  int bad = 0;

  always #4 clk = ~clk;

  irq_preempt_arbiter dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_prio(src_prio),
    .cur_prio(cur_prio), .cpu_irq(cpu_irq), .ack_vec(ack_vec), .win_prio(win_prio)
  );

  typedef struct packed {
    logic [23:0] req;
    logic [3:0]  cur;
    logic        irq;
    logic [8:0]  vec;
    logic [3:0]  pr;
  } row_t;

  // priority of source i is i mod 16 for the table
  localparam row_t TBL [13] = '{
    '{24'h000000, 4'd0,  1'b0, 9'd0,  4'd0 },  // R7 idle
    '{24'h000008, 4'd0,  1'b1, 9'd3,  4'd3 },  // R2
    '{24'h000008, 4'd3,  1'b0, 9'd0,  4'd0 },  // R3 equal
    '{24'h000008, 4'd2,  1'b1, 9'd3,  4'd3 },  // R3 above
    '{24'h200020, 4'd0,  1'b1, 9'd5,  4'd5 },  // R4 tie 5/21
    '{24'h010001, 4'd0,  1'b0, 9'd0,  4'd0 },  // R5 zero levels
    '{24'h008004, 4'd14, 1'b1, 9'd15, 4'd15},  // R2
    '{24'hFFFFFF, 4'd0,  1'b1, 9'd15, 4'd15},  // R2 all
    '{24'hFFFFFF, 4'd15, 1'b0, 9'd0,  4'd0 },  // R3 top current
    '{24'h800080, 4'd6,  1'b1, 9'd7,  4'd7 },  // R4 tie 7/23
    '{24'h800080, 4'd7,  1'b0, 9'd0,  4'd0 },  // R4 tie with R3 gate shut
    '{24'h101000, 4'd4,  1'b1, 9'd12, 4'd12},  // R2
    '{24'h100000, 4'd4,  1'b0, 9'd0,  4'd0 }   // R3
  };

  task automatic check(input string tag, input logic e_irq, input logic [8:0] e_vec,
                       input logic [3:0] e_pr);
    checks++;
    if (cpu_irq !== e_irq || ack_vec !== e_vec || win_prio !== e_pr) begin
      bad++;
      $display("FAIL %s: got irq=%0b vec=%0d prio=%0d expected irq=%0b vec=%0d prio=%0d",
               tag, cpu_irq, ack_vec, win_prio, e_irq, e_vec, e_pr);
    end
  endtask

  task automatic apply(input logic [N-1:0] r, input logic [3:0] c);
    @(negedge clk);
    src_req  = r;
    cur_prio = c;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    $display("FAIL watchdog: got hung expected finish");
    checks++;
    bad++;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) src_prio[i*4 +: 4] = 4'(i % 16);
    src_req = 24'hFFFFFF;
    #1 check("R1 during reset", 1'b0, 9'd0, 4'd0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    src_req = '0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 1'b0, 9'd0, 4'd0);

    for (int t = 0; t < 13; t++) begin
      apply(TBL[t].req, TBL[t].cur);
      check($sformatf("table row %0d", t), TBL[t].irq, TBL[t].vec, TBL[t].pr);
    end

    // R6: three-clock latency
    apply('0, 4'd0);
    @(negedge clk);
    src_req = 24'h000008;
    @(posedge clk); @(posedge clk); #1;
    check("R6 after two edges", 1'b0, 9'd0, 4'd0);
    @(posedge clk); #1;
    check("R6 after three edges", 1'b1, 9'd3, 4'd3);

    // R8: unrequested source with top level is ignored
    src_prio[9*4 +: 4] = 4'd15;
    apply(24'h000010, 4'd0);
    check("R8 idle source ignored", 1'b1, 9'd4, 4'd4);

    // R2: highest vector boundary
    src_prio[23*4 +: 4] = 4'd15;
    apply(24'h800010, 4'd14);
    check("R2 last source", 1'b1, 9'd23, 4'd15);

    // R5: a zero level among requests of a shut gate
    src_prio[23*4 +: 4] = 4'd0;
    apply(24'h800000, 4'd0);
    check("R5 zero level alone", 1'b0, 9'd0, 4'd0);

    // R1: reset while active
    apply(24'h000008, 4'd0);
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R1 reset mid-run", 1'b0, 9'd0, 4'd0);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule